// File: doc/BRIEF.md
# Subroutine Call and Return Unit with Frame Pointer

This block handles subroutine entry and exit in a small stack-machine core. It keeps its own last-in, first-out store of return addresses and a frame pointer that marks the start of the variable area. A call saves the caller's PC and takes the jump target from the top operand. It also moves the frame pointer by a signed immediate. The negated immediate goes back out so the core can place it in the top operand slot.

A return restores the PC from the newest saved address. It moves the frame pointer back by adding the second operand, which by then holds the negated shift. It also asks the operand stack to pop once. The core keeps the top operand as the function result.

All results are registered. They appear on the outputs one clock after the strobe. A call on a full store raises a one-cycle overflow pulse and changes nothing. A return on an empty store raises a one-cycle underflow pulse and changes nothing.

Top module: `callret_unit`

## Requirements
- R1: After synchronous reset the store is empty, the frame pointer equals the `VP_BASE` parameter, and `npc_vld_o`, `a_wr_o`, `pop_o`, `ovf_o` and `unf_o` are all 0.
- R2: One clock after an accepted call, `npc_vld_o` is 1 and `npc_o` equals the low `ADDR_W` bits of `opa_i`.
- R3: One clock after an accepted call, `a_wr_o` is 1, `pop_o` is 0, and `a_val_o` equals the two's-complement negation of `imm_i` sign-extended to `DATA_W` bits.
- R4: An accepted call adds `imm_i`, sign-extended, to the frame pointer modulo 2^`DATA_W`. The new value is visible on `vp_o` one clock later.
- R5: One clock after an accepted return, `npc_vld_o` is 1, `a_wr_o` is 0, and `npc_o` is the `pc_i` saved by the most recent call not yet matched by a return.
- R6: An accepted return adds `opb_i` to the frame pointer modulo 2^`DATA_W` and pulses `pop_o` for one cycle.
- R7: The store holds `DEPTH` return addresses. A call when it is full does not write it. One clock later `ovf_o` is 1, `npc_vld_o` and `a_wr_o` are 0, and `vp_o` is unchanged. Later returns still yield the saved addresses in LIFO order.
- R8: A return when the store is empty produces, one clock later, `unf_o` at 1, `pop_o` and `npc_vld_o` at 0, and an unchanged `vp_o`.
- R9: When `call_i` and `ret_i` are both 1 in a cycle, only the call takes effect.
- R10: In a cycle with neither strobe, the next cycle shows `npc_vld_o`, `a_wr_o`, `pop_o`, `ovf_o` and `unf_o` at 0 and `vp_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| imm_i | input | IMM_W | Signed frame shift for a call |
| opa_i | input | DATA_W | Top operand, the call target |
| opb_i | input | DATA_W | Second operand, added to the frame pointer on return |
| pc_i | input | ADDR_W | Current PC, saved by a call |
| npc_o | output | ADDR_W | Next PC |
| npc_vld_o | output | 1 | `npc_o` must be loaded into the PC |
| a_val_o | output | DATA_W | Value for the top operand |
| a_wr_o | output | 1 | `a_val_o` must be written to the top operand |
| pop_o | output | 1 | Operand stack pop request |
| vp_o | output | DATA_W | Frame pointer |
| ovf_o | output | 1 | Call refused, store full |
| unf_o | output | 1 | Return refused, store empty |

## Verification
Two nested calls with a positive and a negative shift, followed by matching returns, show LIFO ordering of saved PCs. They also show that each return undoes exactly its own call's shift, so the frame pointer returns to its base. Idle cycles between operations show that nothing moves without a strobe.

A return on an empty store and a cycle with both strobes separate correct fault handling and call priority from a design that acts on both strobes. Filling the store to `DEPTH` and then calling once more shows that the overflow is refused without corrupting the store. The full unwind afterwards confirms this, and so does the underflow it ends with.

// File: rtl/callret_pkg.sv
package callret_pkg;
  typedef enum logic [1:0] {
    CRT_IDLE = 2'd0,
    CRT_CALL = 2'd1,
    CRT_RET  = 2'd2
  } crt_op_e;
endpackage

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] rdata_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rd_q;
  logic [PW-1:0]     wptr;
  logic [PW-1:0]     rptr;
  logic              do_push;
  logic              do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o && !push_i;
  assign wptr    = PW'(cnt_q);
  assign rptr    = PW'(cnt_q - 1'b1);
  assign rdata_o = rd_q;

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (do_push) cnt_q <= cnt_q + 1'b1;
    else if (do_pop)  cnt_q <= cnt_q - 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));                                                // R7
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o) |=> $stable(cnt_q));                              // R7
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && empty_o) |=> $stable(cnt_q));                   // R8
endmodule

// File: rtl/frame_ptr.sv
module frame_ptr #(
  parameter int              DATA_W = 16,
  parameter logic [DATA_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_en_i,
  input  logic [DATA_W-1:0] delta_i,
  output logic [DATA_W-1:0] vp_o
);
  logic [DATA_W-1:0] vp_q;

  always_ff @(posedge clk) begin
    if (rst)           vp_q <= BASE;
    else if (add_en_i) vp_q <= vp_q + delta_i;
  end

  assign vp_o = vp_q;

  AST_VP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !add_en_i |=> $stable(vp_o));                                        // R10
  AST_VP_STEP: assert property (@(posedge clk) disable iff (rst)
    add_en_i |=> (vp_o == $past(vp_o) + $past(delta_i)));                // R4
endmodule

// File: rtl/callret_unit.sv
module callret_unit
  import callret_pkg::*;
#(
  parameter int                DEPTH   = 100,
  parameter int                ADDR_W  = 16,
  parameter int                DATA_W  = 16,
  parameter int                IMM_W   = 8,
  parameter logic [DATA_W-1:0] VP_BASE = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] npc_o,
  output logic              npc_vld_o,
  output logic [DATA_W-1:0] a_val_o,
  output logic              a_wr_o,
  output logic              pop_o,
  output logic [DATA_W-1:0] vp_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic              full;
  logic              empty;
  logic              do_call;
  logic              do_ret;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] vp_delta;
  logic [ADDR_W-1:0] ret_addr;

  crt_op_e           op_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [DATA_W-1:0] aval_q;
  logic              ovf_q;
  logic              unf_q;

  generate
    if (IMM_W < DATA_W) begin : g_sext
      assign imm_ext = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  // call has priority over return
  assign do_call  = call_i && !full;
  assign do_ret   = ret_i && !call_i && !empty;
  assign vp_delta = do_call ? imm_ext : opb_i;

  ret_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push_i  (do_call),
    .pop_i   (do_ret),
    .wdata_i (pc_i),
    .rdata_o (ret_addr),
    .full_o  (full),
    .empty_o (empty)
  );

  frame_ptr #(.DATA_W(DATA_W), .BASE(VP_BASE)) u_vp (
    .clk      (clk),
    .rst      (rst),
    .add_en_i (do_call || do_ret),
    .delta_i  (vp_delta),
    .vp_o     (vp_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= CRT_IDLE;
      tgt_q  <= '0;
      aval_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      ovf_q <= call_i && full;
      unf_q <= ret_i && !call_i && empty;
      if (do_call) begin
        op_q   <= CRT_CALL;
        tgt_q  <= opa_i[ADDR_W-1:0];
        aval_q <= '0 - imm_ext;
      end else if (do_ret) begin
        op_q <= CRT_RET;
      end else begin
        op_q <= CRT_IDLE;
      end
    end
  end

  assign npc_vld_o = (op_q != CRT_IDLE);
  assign npc_o     = (op_q == CRT_RET) ? ret_addr : tgt_q;
  assign a_wr_o    = (op_q == CRT_CALL);
  assign a_val_o   = aval_q;
  assign pop_o     = (op_q == CRT_RET);
  assign ovf_o     = ovf_q;
  assign unf_o     = unf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (call_i && full) |=> (ovf_o && !npc_vld_o && !a_wr_o));              // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && empty) |=> (unf_o && !pop_o && !npc_vld_o));    // R8
  AST_CALL_WINS: assert property (@(posedge clk) disable iff (rst)
    (call_i && ret_i) |=> !pop_o);                                       // R9
  AST_CALL_NEG: assert property (@(posedge clk) disable iff (rst)
    do_call |=> (a_wr_o && (a_val_o + $past(imm_ext)) == '0));           // R3
  AST_CALL_TGT: assert property (@(posedge clk) disable iff (rst)
    do_call |=> (npc_o == $past(opa_i[ADDR_W-1:0])));                    // R2
  AST_RET_POP: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && !empty) |=> (pop_o && npc_vld_o));              // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!call_i && !ret_i) |=> !(npc_vld_o || a_wr_o || pop_o || ovf_o || unf_o)); // R10
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_o, unf_o, npc_vld_o}));                                // R7
endmodule

// File: tb/callret_unit_test.sv
module callret_unit_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 100;
  localparam int AW     = 16;
  localparam int DW     = 16;
  localparam int IW     = 8;
  localparam logic [DW-1:0] BASE = 16'h0400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          call_i = 1'b0, ret_i = 1'b0;
  logic [IW-1:0] imm_i = '0;
  logic [DW-1:0] opa_i = '0, opb_i = '0;
  logic [AW-1:0] pc_i = '0;
  logic [AW-1:0] npc_o;
  logic          npc_vld_o, a_wr_o, pop_o, ovf_o, unf_o;
  logic [DW-1:0] a_val_o, vp_o;

  callret_unit #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .IMM_W(IW), .VP_BASE(BASE)) uut (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .imm_i(imm_i),
    .opa_i(opa_i), .opb_i(opb_i), .pc_i(pc_i), .npc_o(npc_o),
    .npc_vld_o(npc_vld_o), .a_val_o(a_val_o), .a_wr_o(a_wr_o), .pop_o(pop_o),
    .vp_o(vp_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    string         req;
    logic          vld;
    logic [AW-1:0] npc;
    logic          awr;
    logic [DW-1:0] aval;
    logic          pop;
    logic [DW-1:0] vp;
    logic          ovf;
    logic          unf;
  } exp_t;

  exp_t          sb[$];
  logic [AW-1:0] mstk[$];
  logic [DW-1:0] mvp;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(logic c, logic r, logic [IW-1:0] imm, logic [DW-1:0] a,
                      logic [DW-1:0] b, logic [AW-1:0] pc);
    exp_t e;
    logic [DW-1:0] sx;
    @(negedge clk);
    call_i = c; ret_i = r; imm_i = imm; opa_i = a; opb_i = b; pc_i = pc;
    sx = {{(DW-IW){imm[IW-1]}}, imm};
    e.vld = 0; e.npc = '0; e.awr = 0; e.aval = '0; e.pop = 0; e.ovf = 0; e.unf = 0;
    if (c) begin
      if (mstk.size() == DEPTH) begin
        e.ovf = 1; e.req = "R7";
      end else begin
        mstk.push_back(pc);
        mvp = mvp + sx;
        e.vld = 1; e.npc = a[AW-1:0]; e.awr = 1; e.aval = -sx;
        e.req = r ? "R9 R2 R3 R4" : "R2 R3 R4";
      end
    end else if (r) begin
      if (mstk.size() == 0) begin
        e.unf = 1; e.req = "R8";
      end else begin
        e.npc = mstk.pop_back();
        mvp = mvp + b;
        e.vld = 1; e.pop = 1; e.req = "R5 R6";
      end
    end else begin
      e.req = "R10";
    end
    e.vp = mvp;
    sb.push_back(e);
  endtask

  // monitor: compare outputs a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "npc_vld", 32'(npc_vld_o), 32'(e.vld));
        if (e.vld) check(e.req, "npc", 32'(npc_o), 32'(e.npc));
        check(e.req, "a_wr", 32'(a_wr_o), 32'(e.awr));
        if (e.awr) check(e.req, "a_val", 32'(a_val_o), 32'(e.aval));
        check(e.req, "pop", 32'(pop_o), 32'(e.pop));
        check(e.req, "vp", 32'(vp_o), 32'(e.vp));
        check(e.req, "ovf", 32'(ovf_o), 32'(e.ovf));
        check(e.req, "unf", 32'(unf_o), 32'(e.unf));
      end
    end
  end

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mvp = BASE;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "vp", 32'(vp_o), 32'(BASE));
    check("R1", "flags", {27'd0, npc_vld_o, a_wr_o, pop_o, ovf_o, unf_o}, 32'd0);

    step(1, 0, 8'd5,  16'h1234, 16'h0,    16'h0010);
    step(1, 0, 8'hFD, 16'h2000, 16'h0,    16'h1235);
    step(0, 0, 8'h11, 16'hAAAA, 16'h5555, 16'h7777);
    step(0, 1, 8'h00, 16'h0,    16'h0003, 16'h0);
    step(0, 1, 8'h00, 16'h0,    16'hFFFB, 16'h0);
    step(0, 1, 8'h00, 16'h0,    16'h0100, 16'h0);   // empty: R8
    step(1, 1, 8'h7F, 16'h3000, 16'h0999, 16'h4444); // both: R9
    step(0, 0, 8'h00, 16'h0,    16'h0,    16'h0);
    step(0, 1, 8'h00, 16'h0,    16'hFF81, 16'h0);
    step(1, 0, 8'h80, 16'h0042, 16'h0,    16'h0050); // most negative shift
    step(0, 1, 8'h00, 16'h0,    16'h0080, 16'h0);

    // fill to DEPTH, overflow, then unwind completely: R7
    for (int k = 0; k < DEPTH; k++)
      step(1, 0, 8'd1, 16'(k + 16'h0500), 16'h0, 16'(k * 3 + 1));
    step(1, 0, 8'd9, 16'hBEEF, 16'h0, 16'hDEAD);
    for (int k = 0; k < DEPTH; k++)
      step(0, 1, 8'd0, 16'h0, 16'hFFFF, 16'h0);
    step(0, 1, 8'd0, 16'h0, 16'h0001, 16'h0);
    step(0, 0, 8'd0, 16'h0, 16'h0, 16'h0);

    @(negedge clk);
    call_i = 0; ret_i = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule